// File: doc/BRIEF.md
# Two-Wire Bus Occupancy Monitor

This block listens to the clock and data lines of a shared two-wire bus (I2C style) and works out whether another master currently holds the bus. It brings both raw line levels into its own clock domain through a short synchronizer chain. It then spots the two framing events: a Start, where data falls while the clock is high, and a Stop, where data rises while the clock is high. Each event is recorded in a sticky status bit. A master controller beside this block reads the bus-free output before it tries to begin a transfer of its own.

Two enables govern the block. The module enable `mon_en_i` turns the whole monitor on; while it is low, both status bits are held clear and no event is recorded. The interrupt enable `evt_irq_en_i` gates a single-cycle event pulse. Each gated pulse also sets a sticky request flag, which firmware clears with a write-one-to-clear strobe. If the interrupt enable is raised while another master holds the bus, the first pulse that follows is the one for that master's Stop. The block has no streaming data path, so every pin is a plain level or strobe and there is no valid/ready handshake.

Top module: `twi_bus_owner_monitor`

## Requirements
- R1: A Start (synchronized data going 1 to 0 while the synchronized clock is 1 on both compared samples) sets `start_seen_o` to 1 and clears `stop_seen_o` to 0.
- R2: A Stop (synchronized data going 0 to 1 while the synchronized clock is 1 on both compared samples) sets `stop_seen_o` to 1 and clears `start_seen_o` to 0.
- R3: A data change while the clock line is low changes neither status bit and produces no event pulse. A repeated Start while the bus is held leaves `start_seen_o` at 1.
- R4: While `mon_en_i` is 0, both status bits read 0 from the next cycle onward, line activity records nothing, and no event pulse is produced.
- R5: While `rst_ni` is 0, both status bits, `irq_pulse_o` and `irq_flag_o` read 0, and `bus_free_o` reads 1.
- R6: `bus_free_o` is 1 when `stop_seen_o` is 1 or when both status bits are 0. It is 0 exactly when `start_seen_o` is 1 and `stop_seen_o` is 0.
- R7: Each detected Start or Stop produces exactly one single-cycle `irq_pulse_o` when `evt_irq_en_i` was 1 in the detection cycle, and no pulse when it was 0. Raising `evt_irq_en_i` while the bus is busy yields no pulse until the next Stop.
- R8: `irq_flag_o` becomes 1 in the same cycle as an `irq_pulse_o`. It holds until a cycle where `irq_clr_i` is 1 and no new pulse is being raised, and then reads 0. A new pulse takes priority over a clear.
- R9: With `SYNC_STAGES` = 2, a line change driven just before a clock edge is reflected in the status bits and in `irq_pulse_o` on the third rising edge after the change, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Monitor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mon_en_i | input | 1 | Module enable; low clears and freezes the status bits |
| scl_i | input | 1 | Bus clock line level, asynchronous |
| sda_i | input | 1 | Bus data line level, asynchronous |
| evt_irq_en_i | input | 1 | Gates the event pulse and the request flag |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the request flag |
| start_seen_o | output | 1 | Sticky Start status bit |
| stop_seen_o | output | 1 | Sticky Stop status bit |
| bus_free_o | output | 1 | High when a master may claim the bus |
| irq_pulse_o | output | 1 | One-cycle pulse per gated Start or Stop |
| irq_flag_o | output | 1 | Sticky interrupt request |

## Verification
The assertions assume that the bus lines never produce two framing events in adjacent monitor cycles. They also assume that a status bit can only rise in a cycle that follows an enabled cycle. The one-cycle pulse check and the pulse-to-status checks rest on these assumptions. The stimulus holds every line level for several clock cycles and changes only one line per step, so each event is separated from the next by at least the synchronizer depth. Enables and the clear strobe are driven on the falling clock edge so that they stay stable across each rising edge.

// File: rtl/twi_mon_pkg.sv
package twi_mon_pkg;

  typedef enum logic [1:0] {
    COND_NONE  = 2'd0,
    COND_START = 2'd1,
    COND_STOP  = 2'd2
  } twi_cond_e;

  localparam int unsigned LINE_COUNT = 2;
  localparam int unsigned LINE_SCL   = 1;
  localparam int unsigned LINE_SDA   = 0;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain_q [STAGES];

  // bus lines idle high, so the chain resets to ones
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= '1;
          else         chain_q[s] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= '1;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
  import twi_mon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      scl_s_i,
  input  logic      sda_s_i,
  output twi_cond_e cond_o
);

  logic scl_prev_q;
  logic sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
    end
  end

  logic clock_high;
  assign clock_high = scl_s_i & scl_prev_q;

  always_comb begin
    cond_o = COND_NONE;
    if (clock_high) begin
      if (sda_prev_q && !sda_s_i)      cond_o = COND_START;
      else if (!sda_prev_q && sda_s_i) cond_o = COND_STOP;
    end
  end

endmodule

// File: rtl/twi_occupancy.sv
module twi_occupancy
  import twi_mon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  input  twi_cond_e cond_i,
  output logic      start_seen_o,
  output logic      stop_seen_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_seen_o <= 1'b0;
      stop_seen_o  <= 1'b0;
    end else if (!enable_i) begin
      start_seen_o <= 1'b0;
      stop_seen_o  <= 1'b0;
    end else begin
      unique case (cond_i)
        COND_START: begin
          start_seen_o <= 1'b1;
          stop_seen_o  <= 1'b0;
        end
        COND_STOP: begin
          start_seen_o <= 1'b0;
          stop_seen_o  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twi_irq_gen.sv
module twi_irq_gen
  import twi_mon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      enable_i,
  input  logic      irq_en_i,
  input  logic      irq_clr_i,
  input  twi_cond_e cond_i,
  output logic      irq_pulse_o,
  output logic      irq_flag_o
);

  logic raise;
  assign raise = enable_i & irq_en_i & (cond_i != COND_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_pulse_o <= 1'b0;
      irq_flag_o  <= 1'b0;
    end else begin
      irq_pulse_o <= raise;
      if (raise)          irq_flag_o <= 1'b1;
      else if (irq_clr_i) irq_flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/twi_bus_owner_monitor.sv
module twi_bus_owner_monitor
  import twi_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_en_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic evt_irq_en_i,
  input  logic irq_clr_i,
  output logic start_seen_o,
  output logic stop_seen_o,
  output logic bus_free_o,
  output logic irq_pulse_o,
  output logic irq_flag_o
);

  logic [LINE_COUNT-1:0] lines_raw;
  logic [LINE_COUNT-1:0] lines_sync;
  twi_cond_e             cond;

  assign lines_raw[LINE_SCL] = scl_i;
  assign lines_raw[LINE_SDA] = sda_i;

  twi_line_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (LINE_COUNT)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (lines_raw),
    .sync_o (lines_sync)
  );

  twi_cond_detect u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_s_i (lines_sync[LINE_SCL]),
    .sda_s_i (lines_sync[LINE_SDA]),
    .cond_o  (cond)
  );

  twi_occupancy u_occ (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (mon_en_i),
    .cond_i       (cond),
    .start_seen_o (start_seen_o),
    .stop_seen_o  (stop_seen_o)
  );

  twi_irq_gen u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (mon_en_i),
    .irq_en_i    (evt_irq_en_i),
    .irq_clr_i   (irq_clr_i),
    .cond_i      (cond),
    .irq_pulse_o (irq_pulse_o),
    .irq_flag_o  (irq_flag_o)
  );

  // busy only while a Start is recorded without a later Stop
  assign bus_free_o = stop_seen_o | ~start_seen_o;

endmodule

// File: rtl/twi_bus_owner_monitor_chk.sv
module twi_bus_owner_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mon_en_i,
  input logic evt_irq_en_i,
  input logic irq_clr_i,
  input logic start_seen_o,
  input logic stop_seen_o,
  input logic bus_free_o,
  input logic irq_pulse_o,
  input logic irq_flag_o
);

  assert_exclusive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_seen_o && stop_seen_o));

  assert_start_needs_enable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_seen_o) |-> $past(mon_en_i));

  assert_stop_needs_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_seen_o) |-> $past(mon_en_i));

  assert_disable_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_en_i |=> (!start_seen_o && !stop_seen_o && !irq_pulse_o));

  assert_busy_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_seen_o && !stop_seen_o) |-> !bus_free_o);

  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |=> !irq_pulse_o);

  assert_pulse_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> $past(evt_irq_en_i));

  assert_pulse_has_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> (start_seen_o || stop_seen_o));

  assert_flag_follows_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> irq_flag_o);

  assert_flag_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag_o) |-> irq_pulse_o);

  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_flag_o) |-> $past(irq_clr_i));

endmodule

bind twi_bus_owner_monitor twi_bus_owner_monitor_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mon_en_i     (mon_en_i),
  .evt_irq_en_i (evt_irq_en_i),
  .irq_clr_i    (irq_clr_i),
  .start_seen_o (start_seen_o),
  .stop_seen_o  (stop_seen_o),
  .bus_free_o   (bus_free_o),
  .irq_pulse_o  (irq_pulse_o),
  .irq_flag_o   (irq_flag_o)
);

// File: tb/test_twi_bus_owner_monitor.sv
module test_twi_bus_owner_monitor;

  localparam time CLK_PERIOD = 10ns;
  localparam int  SETTLE     = 6;
  localparam int  NVEC       = 10;

  // vector bits: [6] scl, [5] sda, [4] irq enable,
  // [3] expected start_seen, [2] expected stop_seen, [1] expected bus_free,
  // [0] expected pulse count in the step
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1110010,  // idle lines, nothing seen
    7'b1011001,  // Start
    7'b0011000,  // clock low
    7'b0111000,  // data change under low clock
    7'b1111000,  // clock rises with data high
    7'b1011001,  // repeated Start
    7'b1110111,  // Stop
    7'b1001000,  // Start with irq disabled
    7'b1011000,  // irq enabled while busy
    7'b1110111   // Stop fires the deferred pulse
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic irq_en = 1'b0;
  logic irq_clr = 1'b0;
  logic start_seen, stop_seen, bus_free, irq_pulse, irq_flag;

  int n_tests = 0;
  int n_fail  = 0;
  int pulse_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (irq_pulse) pulse_cnt <= pulse_cnt + 1;

  twi_bus_owner_monitor #(.SYNC_STAGES(2)) i_twi_bus_owner_monitor (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mon_en_i     (mon_en),
    .scl_i        (scl),
    .sda_i        (sda),
    .evt_irq_en_i (irq_en),
    .irq_clr_i    (irq_clr),
    .start_seen_o (start_seen),
    .stop_seen_o  (stop_seen),
    .bus_free_o   (bus_free),
    .irq_pulse_o  (irq_pulse),
    .irq_flag_o   (irq_flag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    // R5: reset state
    cycles(3);
    check("R5", "start_seen in reset", int'(start_seen), 0);
    check("R5", "stop_seen in reset", int'(stop_seen), 0);
    check("R5", "bus_free in reset", int'(bus_free), 1);
    check("R5", "irq_pulse in reset", int'(irq_pulse), 0);
    check("R5", "irq_flag in reset", int'(irq_flag), 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    cycles(SETTLE);

    // table walk: R1 R2 R3 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      base = pulse_cnt;
      scl = VEC[v][6];
      sda = VEC[v][5];
      irq_en = VEC[v][4];
      cycles(SETTLE);
      check("R1/R2/R3", $sformatf("vec %0d start_seen", v), int'(start_seen), int'(VEC[v][3]));
      check("R1/R2/R3", $sformatf("vec %0d stop_seen", v), int'(stop_seen), int'(VEC[v][2]));
      check("R6", $sformatf("vec %0d bus_free", v), int'(bus_free), int'(VEC[v][1]));
      check("R7", $sformatf("vec %0d pulses", v), pulse_cnt - base, int'(VEC[v][0]));
    end

    // R8: flag set from the pulses above, then cleared by the strobe
    check("R8", "flag after pulses", int'(irq_flag), 1);
    irq_clr = 1'b1;
    cycles(1);
    irq_clr = 1'b0;
    cycles(1);
    check("R8", "flag after clear", int'(irq_flag), 0);

    // R9: latency of a Start (lines now scl=1 sda=1, stop seen)
    sda = 1'b0;
    cycles(2);
    check("R9", "start_seen after two edges", int'(start_seen), 0);
    cycles(1);
    check("R9", "start_seen after three edges", int'(start_seen), 1);
    check("R9", "pulse on third edge", int'(irq_pulse), 1);
    check("R8", "flag with pulse", int'(irq_flag), 1);
    cycles(SETTLE);

    // R8: clear held while a new event raises the flag; set wins
    irq_clr = 1'b1;
    sda = 1'b1;  // Stop
    cycles(SETTLE);
    check("R8", "flag after clear collides with event", int'(irq_flag), 0);
    irq_clr = 1'b0;
    sda = 1'b0;  // Start
    cycles(2);
    irq_clr = 1'b1;
    cycles(1);
    irq_clr = 1'b0;
    check("R8", "set beats clear", int'(irq_flag), 1);
    cycles(SETTLE);

    // R4: disabling clears status and masks activity
    check("R4", "busy before disable", int'(start_seen), 1);
    base = pulse_cnt;
    mon_en = 1'b0;
    cycles(1);
    check("R4", "start_seen cleared on disable", int'(start_seen), 0);
    check("R4", "bus_free while disabled", int'(bus_free), 1);
    sda = 1'b1;  // Stop while disabled
    cycles(SETTLE);
    check("R4", "stop ignored while disabled", int'(stop_seen), 0);
    check("R4", "no pulse while disabled", pulse_cnt - base, 0);
    mon_en = 1'b1;
    cycles(SETTLE);

    // R5: reset in the middle of a busy bus
    sda = 1'b0;
    cycles(SETTLE);
    check("R5", "busy before reset", int'(bus_free), 0);
    rst_n = 1'b0;
    cycles(1);
    check("R5", "start_seen after mid-run reset", int'(start_seen), 0);
    check("R5", "irq_flag after mid-run reset", int'(irq_flag), 0);
    check("R5", "bus_free after mid-run reset", int'(bus_free), 1);
    rst_n = 1'b1;
    cycles(SETTLE);

    finish_run();
  end

endmodule